// File: doc/BRIEF.md
# Permission-flag cache tag controller

This block is the tag and state controller of a set-associative data cache. Each line keeps a tag, one data word and four status bits: valid, readable, writable and dirty. A CPU lookup carries an address, a write flag and a cacheable attribute. The controller answers hits after a fixed latency. It turns misses into requests toward a miss queue, and it sends uncached writes and dirty victims to a write buffer. Refills, write-permission grants and snoops arrive from the memory side and are never refused.

Read and write permission are separate bits. A store that finds its tag present but not writable asks only for permission, and no data moves. A store with no matching tag asks for an exclusive copy of the whole line. A line that holds write permission is the only cached copy, so a snoop that finds it supplies the data and flags the answer so that memory stays silent. The queues and the lower memory are outside the block. They appear only as full flags, request outputs and fill inputs.

Top module: `cc_tag_ctrl`

## Requirements
- R1: A cacheable read hits only when a way in its set is valid, has a matching tag and is readable. The hit returns that way's data word with resp_write_o low.
- R2: A cacheable write hits only when the matching way is valid, readable and writable. The hit replaces the line's data word, marks the line dirty and returns a response with resp_write_o high and zero data.
- R3: A cacheable write whose tag matches a valid but non-writable line issues miss kind 2 (permission upgrade). A fill of kind 2 (grant, no data) to that line makes it writable and dirty and leaves its data unchanged.
- R4: A cacheable write with no matching tag issues miss kind 1 (exclusive fetch). A cacheable read miss issues miss kind 0 (shared fetch). Both use the line-aligned address, with the low OFF_W bits zero.
- R5: A fill of kind 1 installs the line valid, readable, writable and dirty. A fill of kind 0 installs it valid and readable only. Either fill stores fill_data_i and the tag.
- R6: An uncacheable access that matches a line invalidates that line. An uncacheable read issues miss kind 3 with the full address. An uncacheable write goes to the write buffer as kind 1, with the full address and the write data. A fill of kind 3 installs nothing.
- R7: A fill places its line in the lowest-numbered invalid way. If every way is valid, it uses a per-set round-robin pointer starting at way 0. A dirty victim is sent to the write buffer as kind 0 with its line address and data, one cycle after the fill.
- R8: blocked_o is high while the miss queue is full, while the write buffer is full, or while any set has PEND_MAX miss requests still awaiting a fill. Each miss request adds one to its set and each fill removes one.
- R9: While blocked_o is high, or while a fill or snoop is presented, a CPU request is not accepted and changes nothing. Fills and snoops are always taken.
- R10: A hit accepted in cycle c raises resp_valid_o in cycle c+HIT_LAT, the same for reads and writes. Miss and write-buffer requests appear in cycle c+1.
- R11: A snoop reports a hit when a valid line matches its tag. An exclusive snoop invalidates that line. A shared snoop removes write permission and keeps the dirty bit.
- R12: A snoop hit on a writable line raises snp_inhibit_o and drives the line's data on snp_data_o in the same cycle. Otherwise snp_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU lookup present |
| req_write_i | input | 1 | Lookup is a store |
| req_cache_i | input | 1 | Lookup targets cacheable memory |
| req_addr_i | input | ADDR_W | Lookup byte address |
| req_wdata_i | input | DATA_W | Store data |
| req_ready_o | output | 1 | Lookup is accepted this cycle |
| blocked_o | output | 1 | Controller refuses CPU lookups |
| resp_valid_o | output | 1 | Hit response |
| resp_write_o | output | 1 | Response belongs to a store |
| resp_rdata_o | output | DATA_W | Read hit data |
| miss_full_i | input | 1 | Miss queue has no room |
| miss_valid_o | output | 1 | Miss request |
| miss_kind_o | output | 2 | 0 shared, 1 exclusive, 2 upgrade, 3 uncached read |
| miss_addr_o | output | ADDR_W | Miss address |
| wb_full_i | input | 1 | Write buffer has no room |
| wb_valid_o | output | 1 | Write buffer entry |
| wb_kind_o | output | 1 | 0 dirty eviction, 1 uncached write |
| wb_addr_o | output | ADDR_W | Entry address |
| wb_data_o | output | DATA_W | Entry data |
| fill_valid_i | input | 1 | Memory-side response |
| fill_kind_i | input | 2 | 0 shared data, 1 exclusive data, 2 grant, 3 uncached data |
| fill_addr_i | input | ADDR_W | Response address |
| fill_data_i | input | DATA_W | Response data |
| snp_valid_i | input | 1 | Snoop present |
| snp_excl_i | input | 1 | Snoop wants exclusive ownership |
| snp_addr_i | input | ADDR_W | Snoop address |
| snp_hit_o | output | 1 | Snoop matched a valid line |
| snp_inhibit_o | output | 1 | Cache supplies data; memory must not answer |
| snp_data_o | output | DATA_W | Supplied line data |

## Verification
The permission bits are never visible directly at the ports. A wrong readable or writable bit shows up at the next lookup of that line, as a hit where a miss was expected, or as the wrong miss kind one cycle after acceptance. A lost dirty bit or a wrong round-robin pointer stays hidden until the set overflows, and then shows as a missing or misdirected write-buffer entry one cycle after the fill. A snoop reveals writability in the same cycle through the inhibit flag. The bench therefore drives each line through fill, upgrade, snoop and eviction, and compares every output against a behavioural model on every clock.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [1:0] {
    MQ_SHARED = 2'd0,
    MQ_RDEX   = 2'd1,
    MQ_UPGR   = 2'd2,
    MQ_UNC    = 2'd3
  } mq_kind_e;

  typedef enum logic {
    WB_EVICT = 1'b0,
    WB_UNC   = 1'b1
  } wb_kind_e;

  typedef enum logic [1:0] {
    FL_SHARED = 2'd0,
    FL_EXCL   = 2'd1,
    FL_GRANT  = 2'd2,
    FL_UNC    = 2'd3
  } fill_kind_e;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic d;
  } line_st_t;
endpackage

// File: rtl/cc_lookup.sv
`timescale 1ns/1ps
module cc_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 12,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match_o[i]) way_o = WAY_W'(i);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/cc_victim.sv
`timescale 1ns/1ps
module cc_victim #(
  parameter int SETS        = 4,
  parameter int WAYS        = 2,
  parameter int RANDOM_REPL = 0,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] way_o
);
  logic             free_found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] repl_way;

  // lowest invalid way wins
  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(i);
      end
    end
  end

  if (RANDOM_REPL != 0) begin : g_rand
    logic [7:0] lfsr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lfsr_q <= 8'hA5;
      else if (adv_i) lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end
    assign repl_way = WAY_W'(32'(lfsr_q ^ 8'(set_i)) % WAYS);
  end else begin : g_rr
    logic [SETS-1:0][WAY_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
      end else if (adv_i) begin
        ptr_q[set_i] <= (ptr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[set_i] + 1'b1;
      end
    end
    assign repl_way = ptr_q[set_i];
  end

  assign way_o = free_found ? free_way : repl_way;
endmodule

// File: rtl/cc_hit_pipe.sv
`timescale 1ns/1ps
module cc_hit_pipe #(
  parameter int LAT = 2,
  parameter int W   = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [LAT-1:0]        v_q;
  logic [LAT-1:0][W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      d_q <= '0;
    end else begin
      v_q[0] <= valid_i;
      d_q[0] <= data_i;
      for (int i = 1; i < LAT; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign valid_o = v_q[LAT-1];
  assign data_o  = d_q[LAT-1];
endmodule

// File: rtl/cc_tag_ctrl.sv
`timescale 1ns/1ps
module cc_tag_ctrl
  import cc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SETS        = 4,
  parameter int WAYS        = 2,
  parameter int OFF_W       = 2,
  parameter int HIT_LAT     = 2,
  parameter int PEND_MAX    = 2,
  parameter int RANDOM_REPL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_cache_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              blocked_o,
  output logic              resp_valid_o,
  output logic              resp_write_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  input  logic              miss_full_i,
  output logic              miss_valid_o,
  output logic [1:0]        miss_kind_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  input  logic              wb_full_i,
  output logic              wb_valid_o,
  output logic              wb_kind_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  input  logic              fill_valid_i,
  input  logic [1:0]        fill_kind_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              snp_valid_i,
  input  logic              snp_excl_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_hit_o,
  output logic              snp_inhibit_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CNT_W = $clog2(PEND_MAX + 1) + 1;

  line_st_t [SETS-1:0][WAYS-1:0]             st_q;
  logic     [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic     [SETS-1:0][WAYS-1:0][DATA_W-1:0] data_q;
  logic     [SETS-1:0][CNT_W-1:0]            pend_q;

  // address split
  logic [IDX_W-1:0] c_idx, f_idx, s_idx;
  logic [TAG_W-1:0] c_tag, f_tag, s_tag;
  assign c_idx = req_addr_i[OFF_W +: IDX_W];
  assign f_idx = fill_addr_i[OFF_W +: IDX_W];
  assign s_idx = snp_addr_i[OFF_W +: IDX_W];
  assign c_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign f_tag = fill_addr_i[ADDR_W-1 -: TAG_W];
  assign s_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  logic unused_off;
  assign unused_off = ^{fill_addr_i[OFF_W-1:0], snp_addr_i[OFF_W-1:0]};

  logic [WAYS-1:0] c_vld, f_vld, s_vld;
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      c_vld[i] = st_q[c_idx][i].v;
      f_vld[i] = st_q[f_idx][i].v;
      s_vld[i] = st_q[s_idx][i].v;
    end
  end

  logic [WAYS-1:0]  c_match, f_match, s_match;
  logic             c_any, f_any, s_any;
  logic [WAY_W-1:0] c_way, f_hit_way, s_way;

  cc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_c_lkp (
    .valid_i(c_vld), .tags_i(tag_q[c_idx]), .tag_i(c_tag),
    .match_o(c_match), .hit_o(c_any), .way_o(c_way)
  );
  cc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_f_lkp (
    .valid_i(f_vld), .tags_i(tag_q[f_idx]), .tag_i(f_tag),
    .match_o(f_match), .hit_o(f_any), .way_o(f_hit_way)
  );
  cc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_s_lkp (
    .valid_i(s_vld), .tags_i(tag_q[s_idx]), .tag_i(s_tag),
    .match_o(s_match), .hit_o(s_any), .way_o(s_way)
  );

  // CPU side
  line_st_t c_st;
  logic     c_rd_ok, c_wr_ok, pend_full, accept;
  logic     cpu_hit, miss_go, unc_wr, unc_inv;
  mq_kind_e miss_kind;

  assign c_st    = st_q[c_idx][c_way];
  assign c_rd_ok = c_any && c_st.r;
  assign c_wr_ok = c_rd_ok && c_st.w;

  always_comb begin
    pend_full = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      if (pend_q[s] >= CNT_W'(PEND_MAX)) pend_full = 1'b1;
    end
  end

  assign blocked_o   = miss_full_i || wb_full_i || pend_full;
  assign req_ready_o = !blocked_o && !fill_valid_i && !snp_valid_i;
  assign accept      = req_valid_i && req_ready_o;
  assign cpu_hit     = accept && req_cache_i && (req_write_i ? c_wr_ok : c_rd_ok);
  assign miss_go     = accept && !cpu_hit && !(req_write_i && !req_cache_i);
  assign unc_wr      = accept && req_write_i && !req_cache_i;
  assign unc_inv     = accept && !req_cache_i && c_any;

  always_comb begin
    if (!req_cache_i)      miss_kind = MQ_UNC;
    else if (!req_write_i) miss_kind = MQ_SHARED;
    else if (c_any)        miss_kind = MQ_UPGR;
    else                   miss_kind = MQ_RDEX;
  end

  // memory side
  fill_kind_e       f_kind;
  logic             f_alloc, evict;
  logic [WAY_W-1:0] vict_way, f_way;
  line_st_t         v_st, s_st, new_st;

  assign f_kind  = fill_kind_e'(fill_kind_i);
  assign f_alloc = fill_valid_i && (f_kind == FL_SHARED || f_kind == FL_EXCL);

  cc_victim #(.SETS(SETS), .WAYS(WAYS), .RANDOM_REPL(RANDOM_REPL)) i_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (f_idx),
    .valid_i(f_vld),
    .adv_i  (f_alloc && !f_any && (&f_vld)),
    .way_o  (vict_way)
  );

  assign f_way  = f_any ? f_hit_way : vict_way;
  assign v_st   = st_q[f_idx][vict_way];
  assign evict  = f_alloc && !f_any && v_st.v && v_st.d;
  assign new_st = '{v: 1'b1, r: 1'b1, w: (f_kind == FL_EXCL), d: (f_kind == FL_EXCL)};

  assign s_st          = st_q[s_idx][s_way];
  assign snp_hit_o     = snp_valid_i && s_any;
  assign snp_inhibit_o = snp_hit_o && s_st.w;
  assign snp_data_o    = snp_inhibit_o ? data_q[s_idx][s_way] : '0;

  // line state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      tag_q  <= '0;
      data_q <= '0;
      pend_q <= '0;
    end else begin
      if (cpu_hit && req_write_i) begin
        data_q[c_idx][c_way]  <= req_wdata_i;
        st_q[c_idx][c_way].d  <= 1'b1;
      end
      if (unc_inv) st_q[c_idx][c_way] <= '0;
      if (miss_go) pend_q[c_idx] <= pend_q[c_idx] + 1'b1;
      if (fill_valid_i) begin
        if (pend_q[f_idx] != '0) pend_q[f_idx] <= pend_q[f_idx] - 1'b1;
        if (f_alloc) begin
          st_q[f_idx][f_way]   <= new_st;
          tag_q[f_idx][f_way]  <= f_tag;
          data_q[f_idx][f_way] <= fill_data_i;
        end else if (f_kind == FL_GRANT && f_any) begin
          st_q[f_idx][f_hit_way].w <= 1'b1;
          st_q[f_idx][f_hit_way].d <= 1'b1;
        end
      end
      if (snp_hit_o) begin
        if (snp_excl_i) st_q[s_idx][s_way]   <= '0;
        else            st_q[s_idx][s_way].w <= 1'b0;
      end
    end
  end

  // outbound requests
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_valid_o <= 1'b0;
      miss_kind_o  <= '0;
      miss_addr_o  <= '0;
      wb_valid_o   <= 1'b0;
      wb_kind_o    <= 1'b0;
      wb_addr_o    <= '0;
      wb_data_o    <= '0;
    end else begin
      miss_valid_o <= miss_go;
      if (miss_go) begin
        miss_kind_o <= miss_kind;
        miss_addr_o <= req_cache_i ? {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : req_addr_i;
      end
      wb_valid_o <= evict || unc_wr;
      if (evict) begin
        wb_kind_o <= WB_EVICT;
        wb_addr_o <= {tag_q[f_idx][vict_way], f_idx, {OFF_W{1'b0}}};
        wb_data_o <= data_q[f_idx][vict_way];
      end else if (unc_wr) begin
        wb_kind_o <= WB_UNC;
        wb_addr_o <= req_addr_i;
        wb_data_o <= req_wdata_i;
      end
    end
  end

  logic [DATA_W:0] pipe_out;
  cc_hit_pipe #(.LAT(HIT_LAT), .W(DATA_W + 1)) i_hit_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(cpu_hit),
    .data_i ({req_write_i, req_write_i ? {DATA_W{1'b0}} : data_q[c_idx][c_way]}),
    .valid_o(resp_valid_o),
    .data_o (pipe_out)
  );
  assign resp_write_o = pipe_out[DATA_W];
  assign resp_rdata_o = pipe_out[DATA_W-1:0];
endmodule

// File: rtl/cc_tag_ctrl_chk.sv
`timescale 1ns/1ps
module cc_tag_ctrl_chk #(
  parameter int WAYS = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            blocked_o,
  input logic            fill_valid_i,
  input logic            snp_valid_i,
  input logic            miss_full_i,
  input logic            wb_full_i,
  input logic            miss_valid_o,
  input logic            wb_valid_o,
  input logic            snp_hit_o,
  input logic            snp_inhibit_o,
  input logic [WAYS-1:0] c_match
);
  // R8
  miss_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_full_i |=> !miss_valid_o);

  // R8
  wb_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_full_i && !fill_valid_i) |=> !wb_valid_o);

  // R9
  mem_side_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i || snp_valid_i || blocked_o) |=> !miss_valid_o);

  // R12
  inhibit_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_inhibit_o |-> snp_hit_o);

  // R11
  snoop_hit_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |-> snp_valid_i);

  // R1
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(c_match));
endmodule

bind cc_tag_ctrl cc_tag_ctrl_chk #(.WAYS(WAYS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .blocked_o    (blocked_o),
  .fill_valid_i (fill_valid_i),
  .snp_valid_i  (snp_valid_i),
  .miss_full_i  (miss_full_i),
  .wb_full_i    (wb_full_i),
  .miss_valid_o (miss_valid_o),
  .wb_valid_o   (wb_valid_o),
  .snp_hit_o    (snp_hit_o),
  .snp_inhibit_o(snp_inhibit_o),
  .c_match      (c_match)
);

// File: tb/test_cc_tag_ctrl.sv
`timescale 1ns/1ps
module test_cc_tag_ctrl;
  localparam int SETS = 4, WAYS = 2, LAT = 2, PMAX = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_v = 0, req_w = 0, req_c = 0;
  logic [15:0] req_a = '0;
  logic [31:0] req_d = '0;
  logic miss_full = 0, wb_full = 0;
  logic fill_v = 0;
  logic [1:0] fill_k = '0;
  logic [15:0] fill_a = '0;
  logic [31:0] fill_d = '0;
  logic snp_v = 0, snp_x = 0;
  logic [15:0] snp_a = '0;

  logic ready, blocked, resp_v, resp_w, miss_v, wb_v, wb_k, s_hit, s_inh;
  logic [31:0] resp_d, wb_d, s_d;
  logic [1:0] miss_k;
  logic [15:0] miss_a, wb_a;

  always #2 clk = ~clk;

  cc_tag_ctrl i_cc_tag_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v), .req_write_i(req_w), .req_cache_i(req_c),
    .req_addr_i(req_a), .req_wdata_i(req_d),
    .req_ready_o(ready), .blocked_o(blocked),
    .resp_valid_o(resp_v), .resp_write_o(resp_w), .resp_rdata_o(resp_d),
    .miss_full_i(miss_full), .miss_valid_o(miss_v), .miss_kind_o(miss_k), .miss_addr_o(miss_a),
    .wb_full_i(wb_full), .wb_valid_o(wb_v), .wb_kind_o(wb_k), .wb_addr_o(wb_a), .wb_data_o(wb_d),
    .fill_valid_i(fill_v), .fill_kind_i(fill_k), .fill_addr_i(fill_a), .fill_data_i(fill_d),
    .snp_valid_i(snp_v), .snp_excl_i(snp_x), .snp_addr_i(snp_a),
    .snp_hit_o(s_hit), .snp_inhibit_o(s_inh), .snp_data_o(s_d)
  );

  int checks = 0, errors = 0;
  string phase = "R8";
  bit chk_en = 0;

  // behavioural reference
  bit mv[SETS][WAYS], mr[SETS][WAYS], mw[SETS][WAYS], md[SETS][WAYS];
  logic [11:0] mtag[SETS][WAYS];
  logic [31:0] mdat[SETS][WAYS];
  int mrr[SETS], mpend[SETS];
  bit e_pv[LAT], e_pw[LAT];
  logic [31:0] e_pd[LAT];
  bit e_mv, e_wv;
  logic [1:0] e_mk;
  logic e_wk;
  logic [15:0] e_ma, e_wa;
  logic [31:0] e_wd;

  function automatic int find(int idx, logic [11:0] t);
    for (int w = 0; w < WAYS; w++) if (mv[idx][w] && mtag[idx][w] == t) return w;
    return -1;
  endfunction

  function automatic bit m_blocked();
    bit b = miss_full || wb_full;
    for (int s = 0; s < SETS; s++) if (mpend[s] >= PMAX) b = 1;
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        mrr[s] = 0; mpend[s] = 0;
        for (int w = 0; w < WAYS; w++) begin
          mv[s][w] = 0; mr[s][w] = 0; mw[s][w] = 0; md[s][w] = 0; mtag[s][w] = '0; mdat[s][w] = '0;
        end
      end
      for (int i = 0; i < LAT; i++) begin e_pv[i] = 0; e_pw[i] = 0; e_pd[i] = '0; end
      e_mv = 0; e_wv = 0; e_mk = '0; e_wk = 0; e_ma = '0; e_wa = '0; e_wd = '0;
    end else begin
      bit acc;
      int idx, w;
      logic [11:0] t;
      acc = req_v && !m_blocked() && !fill_v && !snp_v;
      for (int i = LAT - 1; i > 0; i--) begin
        e_pv[i] = e_pv[i-1]; e_pw[i] = e_pw[i-1]; e_pd[i] = e_pd[i-1];
      end
      e_pv[0] = 0; e_pw[0] = 0; e_pd[0] = '0;
      e_mv = 0; e_wv = 0;
      if (acc) begin
        idx = req_a[3:2]; t = req_a[15:4]; w = find(idx, t);
        if (req_c && !req_w) begin
          if (w >= 0 && mr[idx][w]) begin e_pv[0] = 1; e_pd[0] = mdat[idx][w]; end
          else begin e_mv = 1; e_mk = 0; e_ma = {req_a[15:2], 2'b00}; mpend[idx]++; end
        end else if (req_c) begin
          if (w >= 0 && mr[idx][w] && mw[idx][w]) begin
            e_pv[0] = 1; e_pw[0] = 1; mdat[idx][w] = req_d; md[idx][w] = 1;
          end else begin
            e_mv = 1; e_mk = (w >= 0) ? 2'd2 : 2'd1; e_ma = {req_a[15:2], 2'b00}; mpend[idx]++;
          end
        end else begin
          if (w >= 0) begin mv[idx][w] = 0; mr[idx][w] = 0; mw[idx][w] = 0; md[idx][w] = 0; end
          if (req_w) begin e_wv = 1; e_wk = 1; e_wa = req_a; e_wd = req_d; end
          else begin e_mv = 1; e_mk = 3; e_ma = req_a; mpend[idx]++; end
        end
      end
      if (fill_v) begin
        idx = fill_a[3:2]; t = fill_a[15:4]; w = find(idx, t);
        if (mpend[idx] > 0) mpend[idx]--;
        if (fill_k <= 2'd1) begin
          if (w < 0) begin
            for (int k = WAYS - 1; k >= 0; k--) if (!mv[idx][k]) w = k;
            if (w < 0) begin
              w = mrr[idx]; mrr[idx] = (mrr[idx] + 1) % WAYS;
              if (md[idx][w]) begin e_wv = 1; e_wk = 0; e_wa = {mtag[idx][w], 2'(idx), 2'b00}; e_wd = mdat[idx][w]; end
            end
          end
          mv[idx][w] = 1; mr[idx][w] = 1; mw[idx][w] = (fill_k == 1); md[idx][w] = (fill_k == 1);
          mtag[idx][w] = t; mdat[idx][w] = fill_d;
        end else if (fill_k == 2'd2 && w >= 0) begin
          mw[idx][w] = 1; md[idx][w] = 1;
        end
      end
      if (snp_v) begin
        idx = snp_a[3:2]; w = find(idx, snp_a[15:4]);
        if (w >= 0) begin
          if (snp_x) begin mv[idx][w] = 0; mr[idx][w] = 0; mw[idx][w] = 0; md[idx][w] = 0; end
          else mw[idx][w] = 0;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      int sw;
      bit eh, ei;
      chk("blocked", 32'(blocked), 32'(m_blocked()));
      chk("ready", 32'(ready), 32'(!m_blocked() && !fill_v && !snp_v));
      chk("resp_valid", 32'(resp_v), 32'(e_pv[LAT-1]));
      if (e_pv[LAT-1]) begin
        chk("resp_write", 32'(resp_w), 32'(e_pw[LAT-1]));
        chk("resp_data", resp_d, e_pd[LAT-1]);
      end
      chk("miss_valid", 32'(miss_v), 32'(e_mv));
      if (e_mv) begin
        chk("miss_kind", 32'(miss_k), 32'(e_mk));
        chk("miss_addr", 32'(miss_a), 32'(e_ma));
      end
      chk("wb_valid", 32'(wb_v), 32'(e_wv));
      if (e_wv) begin
        chk("wb_kind", 32'(wb_k), 32'(e_wk));
        chk("wb_addr", 32'(wb_a), 32'(e_wa));
        chk("wb_data", wb_d, e_wd);
      end
      sw = find(snp_a[3:2], snp_a[15:4]);
      eh = snp_v && sw >= 0;
      ei = eh && mw[snp_a[3:2]][sw];
      chk("snp_hit", 32'(s_hit), 32'(eh));
      chk("snp_inhibit", 32'(s_inh), 32'(ei));
      chk("snp_data", s_d, ei ? mdat[snp_a[3:2]][sw] : 32'h0);
    end
  end

  function automatic logic [15:0] ad(int t, int idx);
    return {12'(t), 2'(idx), 2'b00};
  endfunction

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cpu(bit wr, bit cache, logic [15:0] a, logic [31:0] d);
    req_v = 1; req_w = wr; req_c = cache; req_a = a; req_d = d;
    step(1);
    req_v = 0;
    step(3);
  endtask

  task automatic fill(logic [1:0] k, logic [15:0] a, logic [31:0] d);
    fill_v = 1; fill_k = k; fill_a = a; fill_d = d;
    step(1);
    fill_v = 0;
    step(2);
  endtask

  task automatic snoop(bit x, logic [15:0] a);
    snp_v = 1; snp_x = x; snp_a = a;
    step(1);
    snp_v = 0;
    step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    phase = "R8"; chk_en = 1;     // reset state compared while held
    step(2);
    rst_n = 1;
    step(2);
    phase = "R4"; cpu(1, 1, ad(1, 0), 32'h0);
    phase = "R5"; fill(2'd1, ad(1, 0), 32'h11);
    phase = "R1"; cpu(0, 1, ad(1, 0) | 16'h1, 32'h0);
    phase = "R4"; cpu(0, 1, ad(2, 0), 32'h0);
    phase = "R5"; fill(2'd0, ad(2, 0), 32'h22);
    phase = "R1"; cpu(0, 1, ad(2, 0), 32'h0);
    phase = "R3"; cpu(1, 1, ad(2, 0), 32'h33);
    fill(2'd2, ad(2, 0), 32'hdead);
    phase = "R2"; cpu(1, 1, ad(2, 0), 32'h33);
    cpu(0, 1, ad(2, 0), 32'h0);
    phase = "R7"; fill(2'd0, ad(3, 0), 32'h44);
    cpu(0, 1, ad(1, 0), 32'h0);
    fill(2'd0, ad(4, 0), 32'h66);
    phase = "R6"; cpu(0, 0, ad(3, 0) | 16'h2, 32'h0);
    cpu(0, 1, ad(3, 0), 32'h0);
    phase = "R8"; cpu(0, 1, ad(4, 0), 32'h0);
    phase = "R6"; fill(2'd3, ad(3, 0), 32'h77);
    cpu(0, 1, ad(4, 0), 32'h0);
    cpu(1, 0, ad(9, 2) | 16'h3, 32'h99);
    phase = "R10"; cpu(0, 1, ad(4, 0), 32'h0);
    phase = "R8"; miss_full = 1; cpu(0, 1, ad(4, 0), 32'h0); miss_full = 0;
    wb_full = 1; cpu(1, 0, ad(5, 3), 32'h5); wb_full = 0; step(1);
    phase = "R9";
    req_v = 1; req_w = 0; req_c = 1; req_a = ad(4, 0);
    fill_v = 1; fill_k = 2'd0; fill_a = ad(3, 0); fill_d = 32'h88;
    step(1);
    req_v = 0; fill_v = 0; step(3);
    req_v = 1; req_a = ad(3, 0); snp_v = 1; snp_x = 0; snp_a = ad(7, 3);
    step(1);
    req_v = 0; snp_v = 0; step(3);
    phase = "R12"; cpu(1, 1, ad(5, 1), 32'h0);
    fill(2'd1, ad(5, 1), 32'h55);
    snoop(0, ad(5, 1));
    phase = "R11"; cpu(1, 1, ad(5, 1), 32'h1);
    snoop(1, ad(5, 1));
    cpu(0, 1, ad(5, 1), 32'h0);
    snoop(1, ad(6, 1));
    step(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule